// File: doc/BRIEF.md
# Banked Vector Register Sequencer

This block turns a single floating-point register-file operation into a stream of per-element register-number tuples. A one-cycle start pulse presents the destination, first-source and second-source register fields together with a precision select, a one-operand/two-operand select, a programmed length of 1 to 8 and a stride of 1 or 2. The block classifies the operation from the banks its operands fall in, then issues one tuple per clock until the burst ends.

The register file is viewed as four equal banks. Bank 0 holds scalars and the other three hold vectors, so where the destination and the second source sit decides whether the operation runs once, runs as vector-by-scalar, or runs fully vectorised. Vector operands step through their own bank and wrap at its top, never crossing into a neighbouring bank. Single precision has 32 registers (banks of eight), double precision 16 (banks of four).

Downstream logic consumes the tuples to read operands and write results. Checking that a programmed vector is legal (no self-wrap, no partial overlap) is left to the issuer.

Top module: `banked_vec_seq`

## Requirements
- R1: A single-precision register number is {field[3:0], lsb} with its bank in bits [4:3]; a double-precision register number is {1'b0, field[3:0]} with the lsb input ignored and its bank in bits [3:2].
- R2: A start pulse seen while idle is taken on that clock edge; from the next cycle valid_o and busy_o are high and elem_o is 0.
- R3: When the destination lies in bank 0, exactly one element is issued with mode_o = 0, last_o high, and all three register numbers unchanged even if a source lies in a vector bank.
- R4: When the destination is outside bank 0 and the second source is in bank 0, mode_o = 1; the destination and first source step as vectors (the first source even if it lies in bank 0) and the second source is held for every element.
- R5: When neither the destination nor the second source is in bank 0, mode_o = 2 and all operands step.
- R6: A stepping operand's number for element k is bank*S + ((index + k*T) mod S), with S = 8 for single and 4 for double precision, and T = 2 when stride2_i is 1, else 1.
- R7: With mono_i high there is no first source: n_reg_o is 0 for every element; a vector destination with a bank-0 source broadcasts the fixed source (mode 1), and with both outside bank 0 both step (mode 2).
- R8: A vector operation issues len_m1_i+1 elements on consecutive cycles, elem_o counting from 0, last_o high only on the final one, and valid_o low on the cycle after it.
- R9: busy_o is high exactly while elements are issued; a start pulse during that time, including on the final element, is ignored and launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to launch an operation |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| mono_i | input | 1 | 1 = one-source operation (no first source) |
| len_m1_i | input | 3 | Programmed vector length minus one |
| stride2_i | input | 1 | 1 = stride 2, 0 = stride 1 |
| d_field_i | input | 4 | Destination register field |
| d_lsb_i | input | 1 | Destination extra low bit (single precision) |
| n_field_i | input | 4 | First-source register field |
| n_lsb_i | input | 1 | First-source extra low bit (single precision) |
| m_field_i | input | 4 | Second-source register field |
| m_lsb_i | input | 1 | Second-source extra low bit (single precision) |
| busy_o | output | 1 | Elements are being issued |
| valid_o | output | 1 | Current tuple is valid |
| last_o | output | 1 | Current tuple is the final element |
| elem_o | output | 3 | Element number of the current tuple |
| mode_o | output | 2 | 0 scalar, 1 vector/scalar mix, 2 full vector |
| d_reg_o | output | 5 | Destination register number |
| n_reg_o | output | 5 | First-source register number |
| m_reg_o | output | 5 | Second-source register number |

## Verification
The bench builds the block with its default four-bit register fields and three-bit length, which gives both bank sizes, the full length of eight and stride two in one build. With those values a length-eight single-precision vector starting mid-bank and a double-precision vector of length three wrap within their banks, so the index-wrap path of both precisions is exercised. The behavioural model also covers bank-0 first sources under mixed mode, scalar operations with vector-bank sources, ignored low bits in double precision, and start pulses landing on middle and final elements.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic [1:0] {
    VS_SCALAR = 2'd0,
    VS_MIXED  = 2'd1,
    VS_VECTOR = 2'd2
  } vs_mode_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } vs_state_e;

  localparam int unsigned VS_NUM_OPS = 3;
  localparam int unsigned OP_D = 0;
  localparam int unsigned OP_N = 1;
  localparam int unsigned OP_M = 2;

endpackage

// File: rtl/vseq_regnum.sv
module vseq_regnum #(
  parameter int unsigned FIELD_W = 4,
  localparam int unsigned REG_W  = FIELD_W + 1
) (
  input  logic               dbl_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic               lsb_i,
  output logic [REG_W-1:0]   num_o,
  output logic               bank0_o
);

  // The bank always sits in the top two bits of the field, whatever the
  // precision; only the way the low bit is formed changes.
  always_comb begin
    if (dbl_i) begin
      num_o = {1'b0, field_i};
    end else begin
      num_o = {field_i, lsb_i};
    end
    bank0_o = (field_i[FIELD_W-1 -: 2] == 2'b00);
  end

endmodule

// File: rtl/vseq_stepper.sv
module vseq_stepper #(
  parameter int unsigned REG_W = 5,
  localparam int unsigned SP_IDX = REG_W - 2,
  localparam int unsigned DP_IDX = REG_W - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [REG_W-1:0] init_i,
  input  logic             adv_i,
  input  logic             step_en_i,
  input  logic             dbl_i,
  input  logic             stride2_i,
  output logic [REG_W-1:0] num_o
);

  logic [REG_W-1:0]  num_q;
  logic [REG_W-1:0]  num_d;
  logic [REG_W-1:0]  sp_next;
  logic [REG_W-1:0]  dp_next;
  logic [SP_IDX-1:0] sp_inc;
  logic [DP_IDX-1:0] dp_inc;
  logic              num_en;

  always_comb begin
    sp_inc = stride2_i ? SP_IDX'(2) : SP_IDX'(1);
    dp_inc = stride2_i ? DP_IDX'(2) : DP_IDX'(1);
    // Index arithmetic is truncated to the index width, which is the
    // modulo-bank-size wrap; the bank bits are carried across untouched.
    sp_next = {num_q[REG_W-1 -: 2], num_q[SP_IDX-1:0] + sp_inc};
    dp_next = {1'b0, num_q[REG_W-2 -: 2], num_q[DP_IDX-1:0] + dp_inc};
  end

  always_comb begin
    num_en = load_i | (adv_i & step_en_i);
    if (load_i) begin
      num_d = init_i;
    end else if (dbl_i) begin
      num_d = dp_next;
    end else begin
      num_d = sp_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
    end else if (num_en) begin
      num_q <= num_d;
    end
  end

  assign num_o = num_q;

  // R4
  held_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !step_en_i && !load_i |=> $stable(num_o));

  // R6
  sp_bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !load_i && !dbl_i |=> num_o[REG_W-1 -: 2] == $past(num_o[REG_W-1 -: 2]));

  // R6
  dp_bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !load_i && dbl_i |=> num_o[REG_W-1] == 1'b0
      && num_o[REG_W-2 -: 2] == $past(num_o[REG_W-2 -: 2]));

endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int unsigned LEN_W  = 3,
  parameter int unsigned N_OPS  = VS_NUM_OPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mono_i,
  input  logic             dbl_i,
  input  logic             stride2_i,
  input  logic [LEN_W-1:0] len_m1_i,
  input  logic             d_bank0_i,
  input  logic             m_bank0_i,
  output logic             load_o,
  output logic             adv_o,
  output logic [N_OPS-1:0] step_en_o,
  output logic             dbl_o,
  output logic             stride2_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic             last_o,
  output logic [LEN_W-1:0] elem_o,
  output vs_mode_e         mode_o
);

  vs_state_e        state_q, state_d;
  logic [LEN_W-1:0] elem_q, elem_d;
  logic [LEN_W-1:0] lastix_q;
  logic [N_OPS-1:0] step_q;
  vs_mode_e         mode_q;
  logic             dbl_q;
  logic             stride2_q;

  vs_mode_e         cls_mode;
  logic [N_OPS-1:0] cls_step;
  logic [LEN_W-1:0] cls_lastix;

  logic accept;
  logic at_last;
  logic elem_en;

  // Classification from operand banks.
  always_comb begin
    cls_step = '0;
    if (d_bank0_i) begin
      cls_mode   = VS_SCALAR;
      cls_lastix = '0;
    end else if (m_bank0_i) begin
      cls_mode         = VS_MIXED;
      cls_lastix       = len_m1_i;
      cls_step[OP_D]   = 1'b1;
      cls_step[OP_N]   = ~mono_i;
    end else begin
      cls_mode         = VS_VECTOR;
      cls_lastix       = len_m1_i;
      cls_step[OP_D]   = 1'b1;
      cls_step[OP_N]   = ~mono_i;
      cls_step[OP_M]   = 1'b1;
    end
  end

  // Next-state logic.
  always_comb begin
    accept  = start_i && (state_q == ST_IDLE);
    at_last = (elem_q == lastix_q);
    adv_o   = (state_q == ST_ISSUE) && !at_last;
    elem_en = accept | adv_o;
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept)  state_d = ST_ISSUE;
      ST_ISSUE: if (at_last) state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
    elem_d = accept ? '0 : elem_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q <= '0;
    end else if (elem_en) begin
      elem_q <= elem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastix_q  <= '0;
      step_q    <= '0;
      mode_q    <= VS_SCALAR;
      dbl_q     <= 1'b0;
      stride2_q <= 1'b0;
    end else if (accept) begin
      lastix_q  <= cls_lastix;
      step_q    <= cls_step;
      mode_q    <= cls_mode;
      dbl_q     <= dbl_i;
      stride2_q <= stride2_i;
    end
  end

  assign load_o    = accept;
  assign step_en_o = step_q;
  assign dbl_o     = dbl_q;
  assign stride2_o = stride2_q;
  assign busy_o    = (state_q == ST_ISSUE);
  assign valid_o   = (state_q == ST_ISSUE);
  assign last_o    = (state_q == ST_ISSUE) && at_last;
  assign elem_o    = elem_q;
  assign mode_o    = mode_q;

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> valid_o && elem_o == '0);

  // R8
  elem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o |=> valid_o && elem_o == LEN_W'($past(elem_o) + 1'b1));

  // R8
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !valid_o);

  // R3
  scalar_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && mode_o == VS_SCALAR |-> last_o && elem_o == '0);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !last_o |=> elem_o != '0);

endmodule

// File: rtl/banked_vec_seq.sv
module banked_vec_seq
  import vseq_pkg::*;
#(
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned LEN_W   = 3,
  localparam int unsigned REG_W  = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               dbl_i,
  input  logic               mono_i,
  input  logic [LEN_W-1:0]   len_m1_i,
  input  logic               stride2_i,
  input  logic [FIELD_W-1:0] d_field_i,
  input  logic               d_lsb_i,
  input  logic [FIELD_W-1:0] n_field_i,
  input  logic               n_lsb_i,
  input  logic [FIELD_W-1:0] m_field_i,
  input  logic               m_lsb_i,
  output logic               busy_o,
  output logic               valid_o,
  output logic               last_o,
  output logic [LEN_W-1:0]   elem_o,
  output logic [1:0]         mode_o,
  output logic [REG_W-1:0]   d_reg_o,
  output logic [REG_W-1:0]   n_reg_o,
  output logic [REG_W-1:0]   m_reg_o
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [FIELD_W-1:0]    fld   [VS_NUM_OPS];
  logic                  lsb   [VS_NUM_OPS];
  logic [REG_W-1:0]      num   [VS_NUM_OPS];
  logic [REG_W-1:0]      init  [VS_NUM_OPS];
  logic [REG_W-1:0]      cur   [VS_NUM_OPS];
  logic [VS_NUM_OPS-1:0] bank0;
  logic [VS_NUM_OPS-1:0] step_en;
  logic                  load;
  logic                  adv;
  logic                  dbl_q;
  logic                  stride2_q;
  vs_mode_e              mode;

  assign fld[OP_D] = d_field_i;
  assign fld[OP_N] = n_field_i;
  assign fld[OP_M] = m_field_i;
  assign lsb[OP_D] = d_lsb_i;
  assign lsb[OP_N] = n_lsb_i;
  assign lsb[OP_M] = m_lsb_i;

  // One-source operations carry no first source: it loads as zero.
  always_comb begin
    for (int i = 0; i < VS_NUM_OPS; i++) begin
      init[i] = num[i];
    end
    if (mono_i) begin
      init[OP_N] = '0;
    end
  end

  genvar g;
  generate
    for (g = 0; g < VS_NUM_OPS; g++) begin : g_op
      vseq_regnum #(
        .FIELD_W (FIELD_W)
      ) u_regnum (
        .dbl_i   (dbl_i),
        .field_i (fld[g]),
        .lsb_i   (lsb[g]),
        .num_o   (num[g]),
        .bank0_o (bank0[g])
      );

      vseq_stepper #(
        .REG_W (REG_W)
      ) u_step (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .load_i    (load),
        .init_i    (init[g]),
        .adv_i     (adv),
        .step_en_i (step_en[g]),
        .dbl_i     (dbl_q),
        .stride2_i (stride2_q),
        .num_o     (cur[g])
      );
    end
  endgenerate

  vseq_ctrl #(
    .LEN_W (LEN_W),
    .N_OPS (VS_NUM_OPS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .mono_i    (mono_i),
    .dbl_i     (dbl_i),
    .stride2_i (stride2_i),
    .len_m1_i  (len_m1_i),
    .d_bank0_i (bank0[OP_D]),
    .m_bank0_i (bank0[OP_M]),
    .load_o    (load),
    .adv_o     (adv),
    .step_en_o (step_en),
    .dbl_o     (dbl_q),
    .stride2_o (stride2_q),
    .busy_o    (busy_o),
    .valid_o   (valid_o),
    .last_o    (last_o),
    .elem_o    (elem_o),
    .mode_o    (mode)
  );

  assign mode_o  = mode;
  assign d_reg_o = cur[OP_D];
  assign n_reg_o = cur[OP_N];
  assign m_reg_o = cur[OP_M];

  // R7
  mono_no_first_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load && mono_i |=> n_reg_o == '0);

  // R3
  scalar_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load && bank0[OP_D] |=> d_reg_o == $past(num[OP_D]) && m_reg_o == $past(num[OP_M]));

endmodule

// File: tb/banked_vec_seq_test.sv
`timescale 1ns/1ps
module banked_vec_seq_test;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       dbl_i;
  logic       mono_i;
  logic [2:0] len_m1_i;
  logic       stride2_i;
  logic [3:0] d_field_i, n_field_i, m_field_i;
  logic       d_lsb_i, n_lsb_i, m_lsb_i;
  logic       busy_o, valid_o, last_o;
  logic [2:0] elem_o;
  logic [1:0] mode_o;
  logic [4:0] d_reg_o, n_reg_o, m_reg_o;

  int checks;
  int errors;
  bit done;

  banked_vec_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbl_i(dbl_i), .mono_i(mono_i),
    .len_m1_i(len_m1_i), .stride2_i(stride2_i),
    .d_field_i(d_field_i), .d_lsb_i(d_lsb_i),
    .n_field_i(n_field_i), .n_lsb_i(n_lsb_i),
    .m_field_i(m_field_i), .m_lsb_i(m_lsb_i),
    .busy_o(busy_o), .valid_o(valid_o), .last_o(last_o), .elem_o(elem_o),
    .mode_o(mode_o), .d_reg_o(d_reg_o), .n_reg_o(n_reg_o), .m_reg_o(m_reg_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: register number of element k of an operand.
  function automatic int model_reg(input int base, input int k, input bit steps,
                                   input int bsize, input int stride);
    if (!steps) return base;
    return (base / bsize) * bsize + ((base % bsize) + k * stride) % bsize;
  endfunction

  task automatic drive_regs(input bit dbl, input int dn, input int nn, input int mn);
    if (dbl) begin
      d_field_i = 4'(dn); n_field_i = 4'(nn); m_field_i = 4'(mn);
      // R1: low bits are don't-care in double precision
      d_lsb_i = 1'b1; n_lsb_i = 1'b1; m_lsb_i = 1'b1;
    end else begin
      d_field_i = 4'(dn >> 1); n_field_i = 4'(nn >> 1); m_field_i = 4'(mn >> 1);
      d_lsb_i = 1'(dn & 1); n_lsb_i = 1'(nn & 1); m_lsb_i = 1'(mn & 1);
    end
  endtask

  // poke: element index at which a stray start is raised (-1 = none).
  task automatic run_op(input bit dbl, input bit mono, input int len, input int stride,
                        input int dn, input int nn, input int mn, input int poke,
                        input string tag);
    int bsize, cnt, mode;
    bit sd, sn, sm;
    bsize = dbl ? 4 : 8;
    if (dn / bsize == 0) begin
      mode = 0; cnt = 1; sd = 0; sn = 0; sm = 0;
    end else if (mn / bsize == 0) begin
      mode = 1; cnt = len; sd = 1; sn = !mono; sm = 0;
    end else begin
      mode = 2; cnt = len; sd = 1; sn = !mono; sm = 1;
    end
    @(negedge clk);
    dbl_i = dbl; mono_i = mono; len_m1_i = 3'(len - 1); stride2_i = (stride == 2);
    drive_regs(dbl, dn, nn, mn);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    drive_regs(dbl, 0, 0, 0);
    for (int k = 0; k < cnt; k++) begin
      int ed, en, em;
      ed = model_reg(dn, k, sd, bsize, stride);
      en = mono ? 0 : model_reg(nn, k, sn, bsize, stride);
      em = model_reg(mn, k, sm, bsize, stride);
      check(valid_o && busy_o, {tag, " R2 R9 valid/busy"}, {valid_o, busy_o}, 3);
      check(int'(elem_o) == k, {tag, " R8 elem"}, elem_o, k);
      check(last_o == (k == cnt - 1), {tag, " R8 last"}, last_o, (k == cnt - 1));
      check(int'(mode_o) == mode, {tag, " R3 R4 R5 mode"}, mode_o, mode);
      check(int'(d_reg_o) == ed, {tag, " R1 R6 dest"}, d_reg_o, ed);
      check(int'(n_reg_o) == en, {tag, " R4 R7 first src"}, n_reg_o, en);
      check(int'(m_reg_o) == em, {tag, " R4 R5 second src"}, m_reg_o, em);
      if (k == poke) begin
        // R9: stray start while busy
        start_i = 1'b1;
        drive_regs(dbl, 30, 30, 30);
        len_m1_i = 3'd7;
      end
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
    end
    check(!valid_o && !busy_o && !last_o, {tag, " R8 R9 idle after burst"},
          {valid_o, busy_o, last_o}, 0);
    @(negedge clk);
    check(!valid_o, {tag, " R9 no relaunch"}, valid_o, 0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; start_i = 1'b0; dbl_i = 1'b0; mono_i = 1'b0;
    len_m1_i = '0; stride2_i = 1'b0;
    d_field_i = '0; n_field_i = '0; m_field_i = '0;
    d_lsb_i = 1'b0; n_lsb_i = 1'b0; m_lsb_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!valid_o && !busy_o && !last_o, "reset R2 idle", {valid_o, busy_o, last_o}, 0);

    // R3: single precision scalar with vector-bank sources, length ignored
    run_op(0, 0, 8, 1, 5, 20, 13, -1, "sp_scalar");
    // R4: mixed, first source in bank 0 still steps
    run_op(0, 0, 4, 1, 9, 3, 2, -1, "sp_mixed");
    // R5 R6: full vector, stride 2 with wrap
    run_op(0, 0, 4, 2, 14, 22, 31, -1, "sp_vec_s2");
    // R6: length 8 stride 1 wrapping mid-bank
    run_op(0, 0, 8, 1, 27, 13, 19, -1, "sp_vec_len8");
    // R1 R6: double precision vector, wrap at 4
    run_op(1, 0, 3, 1, 6, 11, 14, -1, "dp_vec");
    // R4 R6: double precision mixed, stride 2
    run_op(1, 0, 2, 2, 13, 5, 1, -1, "dp_mixed_s2");
    // R3: double precision scalar
    run_op(1, 0, 5, 1, 2, 9, 15, -1, "dp_scalar");
    // R7: one-source broadcast
    run_op(0, 1, 5, 1, 17, 9, 4, -1, "mono_bcast");
    // R7: one-source both stepping
    run_op(0, 1, 3, 2, 24, 9, 15, -1, "mono_vec");
    // R7: one-source scalar
    run_op(1, 1, 4, 1, 3, 9, 10, -1, "mono_scalar");
    // R9: stray start in the middle and on the final element
    run_op(0, 0, 4, 1, 8, 16, 24, 1, "busy_mid");
    run_op(1, 0, 3, 1, 4, 8, 12, 2, "busy_last");
    // R8: length 1 vector
    run_op(0, 0, 1, 2, 30, 21, 12, -1, "sp_len1");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule